// File: doc/BRIEF.md
# Stereo Serial Audio Transmitter (Left-Justified / I2S)

This block takes parallel stereo sample pairs, 18-bit two's complement per channel, and sends them over a three-wire serial audio link made of a bit clock, a word-select clock and a data line. The left and right words of one pair always travel together in one word-select frame, so both words of a frame describe the same sampling instant. A static format input picks either left-justified framing or I2S framing. In I2S framing the word-select polarity is swapped and the MSB is delayed by one bit slot.

A static mode input picks how the link clocks are made. In master mode the block divides its own clock by 4 to make the bit clock and by 256 to make the word-select clock, and drives both out. In slave mode an external device drives both clocks. The block oversamples them with its own clock, finds the falling bit-clock edges and the word-select changes, and derives the bit slots from those. Producers hand over sample pairs through a valid/ready handshake into a one-pair holding register. The holding register is copied into the active pair at the start of each left half-frame. If no new pair is waiting at that point, the previous pair is sent again.

Top module: `stereo_ser_tx`

## Requirements
- R1: In master mode `bclk_o` has a period of 4 clock cycles, 2 high and 2 low. `ws_o` toggles every 128 clock cycles, which gives 32 bit slots per half-frame and 64 per frame.
- R2: In master mode `ws_o` and `sdata` change only in the cycle in which `bclk_o` falls. They are therefore stable at every rising bit-clock edge.
- R3: With `fmt_i2s`=0 (left-justified), the left word is sent while word-select is high and the right word while it is low. The MSB goes out in slot 0, the slot that starts with the word-select change. The other 17 bits follow MSB first, one per slot.
- R4: With `fmt_i2s`=1 (I2S), the left word is sent while word-select is low and the right word while it is high. Slot 0 of each half is low, and the MSB goes out in slot 1.
- R5: Every slot of a half-frame that does not carry one of the 18 data bits is driven low.
- R6: `in_ready` is high exactly when the holding register is empty. A pair is accepted in a cycle with `in_valid` and `in_ready` both high. `in_ready` is low from the next cycle until that pair has moved into the active pair.
- R7: A held pair becomes the active pair at the start of the next left half-frame. Both words of every frame come from one accepted pair.
- R8: If no pair is held at the start of a left half-frame, the previous active pair is sent again.
- R9: In slave mode, bit slots start at the falling edges of `bclk_in` and half-frames start at changes of `ws_in`. The format rules R3 to R5 apply unchanged. The input bit clock must be slow enough that each of its half periods spans at least 4 clock cycles, and each half-frame needs at least 18 slots (left-justified) or 19 slots (I2S); a half-frame with fewer slots loses its trailing bits.
- R10: In slave mode `bclk_o` and `ws_o` are held low. In master mode `bclk_in` and `ws_in` have no effect on the output.
- R11: While reset is applied, `sdata` and `bclk_o` are low and `in_ready` is high. `ws_o` sits at the left level in master mode (high for left-justified, low for I2S) and is low in slave mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; in master mode this is the clock that is divided down |
| rst_n | input | 1 | Synchronous reset, active low |
| master | input | 1 | 1: generate link clocks, 0: follow external link clocks (static) |
| fmt_i2s | input | 1 | 0: left-justified framing, 1: I2S framing (static) |
| in_valid | input | 1 | Sample pair on `in_left`/`in_right` is valid |
| in_left | input | 18 | Left sample, two's complement |
| in_right | input | 18 | Right sample, two's complement |
| in_ready | output | 1 | Holding register can take a pair |
| bclk_in | input | 1 | External bit clock (slave mode) |
| ws_in | input | 1 | External word-select clock (slave mode) |
| bclk_o | output | 1 | Generated bit clock (master mode) |
| ws_o | output | 1 | Generated word-select clock (master mode) |
| sdata | output | 1 | Serial data, changes after falling bit-clock edges |

## Verification
In master mode `sdata`, `bclk_o` and `ws_o` come from registers updated on the same clock edge, so a new bit is due in exactly the cycle the bit clock falls. In slave mode the bit is due three clock cycles after a falling `bclk_in` edge: two synchronizer stages and the output register. The bench drives a slow external bit clock, with 8 clock cycles per half period, so every bit has settled well before the next rising edge. `in_ready` is due low in the cycle after acceptance, and an accepted pair is due in the first frame whose left half starts after the acceptance. The bench therefore submits a pair just after a left half has started and compares the next whole frame it decodes. It samples the serial line only at rising bit-clock edges and samples handshake and reset values at falling clock edges, never at the edge where they change.

// File: rtl/sst_pkg.sv
// Shared constants and types for the stereo serial transmitter.
// Assumes: one sample width for both channels.
package sst_pkg;
    parameter int SAMPLE_W        = 18;  // bits per channel word
    parameter int BCLK_DIV_LOG2   = 2;   // master: clk / bit clock = 2**this
    parameter int HALF_SLOTS_LOG2 = 5;   // master: bit slots per half-frame = 2**this
    parameter int SLOT_IDX_W      = 6;   // slot index width, also covers slave halves up to 63
    parameter int SYNC_STAGES     = 2;   // synchronizer depth for slave clock inputs

    typedef struct packed {
        logic [SAMPLE_W-1:0] left;
        logic [SAMPLE_W-1:0] right;
    } pair_t;
endpackage

// File: rtl/sst_master_div.sv
// Master clock divider: derives bit clock and word-select from clk and
// reports the bit slot that starts on the next edge.
// Assumes: en and fmt_i2s change only while reset is applied.
module sst_master_div #(
    parameter int DIV_LOG2  = sst_pkg::BCLK_DIV_LOG2,
    parameter int HALF_LOG2 = sst_pkg::HALF_SLOTS_LOG2,
    parameter int IDX_W     = sst_pkg::SLOT_IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             fmt_i2s,
    output logic             bclk_q,
    output logic             ws_q,
    output logic             slot_evt,
    output logic [IDX_W-1:0] slot_idx,
    output logic             half_left
);
    localparam int CNT_W = DIV_LOG2 + HALF_LOG2 + 1;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cnt_nxt;

    // Next value of the frame counter and the slot it opens.
    always_comb begin
        cnt_nxt   = cnt + 1'b1;
        slot_evt  = en && (cnt_nxt[DIV_LOG2-1:0] == '0);
        slot_idx  = IDX_W'(cnt_nxt[CNT_W-2:DIV_LOG2]);
        half_left = ~cnt_nxt[CNT_W-1];
    end

    // Frame counter and registered link clocks, all on one edge.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt    <= '0;
            bclk_q <= 1'b0;
            ws_q   <= en & ~fmt_i2s;
        end else begin
            cnt    <= cnt_nxt;
            bclk_q <= cnt_nxt[DIV_LOG2-1];
            ws_q   <= cnt_nxt[CNT_W-1] ^ ~fmt_i2s;
        end
    end
endmodule

// File: rtl/sst_slave_sync.sv
// Slave clock follower: synchronizes external bit clock and word-select,
// turns each falling bit-clock edge into a slot event and counts slots
// since the last word-select change.
// Assumes: each bit-clock half period spans at least 4 clk cycles.
module sst_slave_sync #(
    parameter int SYNC_N = sst_pkg::SYNC_STAGES,
    parameter int IDX_W  = sst_pkg::SLOT_IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             fmt_i2s,
    input  logic             bclk_in,
    input  logic             ws_in,
    output logic             slot_evt,
    output logic [IDX_W-1:0] slot_idx,
    output logic             half_left
);
    logic [SYNC_N-1:0] b_sync;
    logic [SYNC_N-1:0] w_sync;
    logic              b_dly;
    logic              ws_last;
    logic [IDX_W-1:0]  slot;
    logic              b_s;
    logic              w_s;
    logic              new_half;

    // Edge detection and next slot index.
    always_comb begin
        b_s       = b_sync[SYNC_N-1];
        w_s       = w_sync[SYNC_N-1];
        slot_evt  = en && b_dly && !b_s;
        new_half  = (w_s != ws_last);
        half_left = (w_s == ~fmt_i2s);
        if (new_half)
            slot_idx = '0;
        else if (slot == '1)
            slot_idx = slot;
        else
            slot_idx = slot + 1'b1;
    end

    // Synchronizers, delayed bit clock and slot state.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            b_sync  <= '0;
            w_sync  <= '0;
            b_dly   <= 1'b0;
            ws_last <= 1'b0;
            slot    <= '1;
        end else begin
            b_sync <= {b_sync[SYNC_N-2:0], bclk_in};
            w_sync <= {w_sync[SYNC_N-2:0], ws_in};
            b_dly  <= b_s;
            if (slot_evt) begin
                slot    <= slot_idx;
                ws_last <= w_s;
            end
        end
    end
endmodule

// File: rtl/sst_frame_eng.sv
// Frame engine: one-pair holding register behind a valid/ready handshake,
// the active pair, and a single shifter serving both framings.
// Assumes: slot events arrive with the index of the slot they open.
module sst_frame_eng #(
    parameter int W     = sst_pkg::SAMPLE_W,
    parameter int IDX_W = sst_pkg::SLOT_IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fmt_i2s,
    input  logic             slot_evt,
    input  logic [IDX_W-1:0] slot_idx,
    input  logic             half_left,
    input  logic             in_valid,
    input  logic [W-1:0]     in_left,
    input  logic [W-1:0]     in_right,
    output logic             in_ready,
    output logic             sdata
);
    import sst_pkg::pair_t;

    pair_t            hold;
    pair_t            cur;
    pair_t            nxt_pair;
    logic             hold_full;
    logic [W-1:0]     sh;
    logic [W-1:0]     word;
    logic             left_start;
    logic [IDX_W-1:0] first_slot;
    logic             sd_q;

    // Slot decode: latch point, data start slot and word to load.
    always_comb begin
        left_start = slot_evt && (slot_idx == '0) && half_left;
        nxt_pair   = hold_full ? hold : cur;
        first_slot = IDX_W'(fmt_i2s);
        if (!half_left)
            word = cur.right;
        else if (left_start)
            word = nxt_pair.left;
        else
            word = cur.left;
    end

    // Holding register and handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold      <= '0;
            hold_full <= 1'b0;
        end else if (left_start && hold_full) begin
            hold_full <= 1'b0;
        end else if (in_valid && !hold_full) begin
            hold.left  <= in_left;
            hold.right <= in_right;
            hold_full  <= 1'b1;
        end
    end

    // Active pair, updated only at the start of a left half-frame.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cur <= '0;
        else if (left_start)
            cur <= nxt_pair;
    end

    // Shared shifter: load at the data start slot, zero-fill afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh   <= '0;
            sd_q <= 1'b0;
        end else if (slot_evt) begin
            if (slot_idx == first_slot) begin
                sd_q <= word[W-1];
                sh   <= {word[W-2:0], 1'b0};
            end else if (slot_idx < first_slot) begin
                sd_q <= 1'b0;
                sh   <= '0;
            end else begin
                sd_q <= sh[W-1];
                sh   <= {sh[W-2:0], 1'b0};
            end
        end
    end

    assign in_ready = !hold_full;
    assign sdata    = sd_q;
endmodule

// File: rtl/stereo_ser_tx.sv
// Stereo serial audio transmitter top: picks the master divider or the
// slave follower as slot source and feeds the shared frame engine.
// Assumes: master and fmt_i2s are static outside reset.
module stereo_ser_tx #(
    parameter int SAMPLE_W = sst_pkg::SAMPLE_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                master,
    input  logic                fmt_i2s,
    input  logic                in_valid,
    input  logic [SAMPLE_W-1:0] in_left,
    input  logic [SAMPLE_W-1:0] in_right,
    output logic                in_ready,
    input  logic                bclk_in,
    input  logic                ws_in,
    output logic                bclk_o,
    output logic                ws_o,
    output logic                sdata
);
    localparam int IDX_W = sst_pkg::SLOT_IDX_W;

    logic             m_evt, s_evt, evt;
    logic [IDX_W-1:0] m_idx, s_idx, idx;
    logic             m_left, s_left, hleft;

    sst_master_div u_mdiv (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (master),
        .fmt_i2s  (fmt_i2s),
        .bclk_q   (bclk_o),
        .ws_q     (ws_o),
        .slot_evt (m_evt),
        .slot_idx (m_idx),
        .half_left(m_left)
    );

    sst_slave_sync u_ssync (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (!master),
        .fmt_i2s  (fmt_i2s),
        .bclk_in  (bclk_in),
        .ws_in    (ws_in),
        .slot_evt (s_evt),
        .slot_idx (s_idx),
        .half_left(s_left)
    );

    // Slot source select by mode.
    always_comb begin
        evt   = master ? m_evt  : s_evt;
        idx   = master ? m_idx  : s_idx;
        hleft = master ? m_left : s_left;
    end

    sst_frame_eng #(.W(SAMPLE_W)) u_eng (
        .clk      (clk),
        .rst_n    (rst_n),
        .fmt_i2s  (fmt_i2s),
        .slot_evt (evt),
        .slot_idx (idx),
        .half_left(hleft),
        .in_valid (in_valid),
        .in_left  (in_left),
        .in_right (in_right),
        .in_ready (in_ready),
        .sdata    (sdata)
    );
endmodule

// File: rtl/sst_checks.sv
// Port-level timing properties of the transmitter, bound to the top.
module sst_checks (
    input logic clk,
    input logic rst_n,
    input logic master,
    input logic fmt_i2s,
    input logic in_valid,
    input logic in_ready,
    input logic bclk_o,
    input logic ws_o,
    input logic sdata
);
    p_bclk_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
        master && $rose(bclk_o) |=> bclk_o);
    p_bclk_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
        master && $fell(bclk_o) |=> !bclk_o);
    p_ws_on_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
        master && !$stable(ws_o) |-> $fell(bclk_o));
    p_data_on_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
        master && !$stable(sdata) |-> $fell(bclk_o));
    p_lead_slot_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        master && fmt_i2s && !$stable(ws_o) |-> !sdata);
    p_ready_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> !in_ready);
    p_slave_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !master |-> !bclk_o && !ws_o);
endmodule

bind stereo_ser_tx sst_checks u_chk (.*);

// File: tb/sim_stereo_ser_tx.sv
module sim_stereo_ser_tx;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        master_r = 1'b1;
    logic        fmt_r = 1'b0;
    logic        in_valid = 1'b0;
    logic [17:0] in_left = '0;
    logic [17:0] in_right = '0;
    logic        in_ready;
    logic        bclk_in = 1'b0;
    logic        ws_in = 1'b0;
    logic        bclk_o, ws_o, sdata;

    int nchk = 0;
    int nbad = 0;
    int cyc  = 0;
    bit done = 0;

    always #4 clk = ~clk;  // 125 MHz

    stereo_ser_tx u0 (
        .clk(clk), .rst_n(rst_n), .master(master_r), .fmt_i2s(fmt_r),
        .in_valid(in_valid), .in_left(in_left), .in_right(in_right),
        .in_ready(in_ready), .bclk_in(bclk_in), .ws_in(ws_in),
        .bclk_o(bclk_o), .ws_o(ws_o), .sdata(sdata)
    );

    // External link clock generator (slave tests, and noise in master).
    bit sl_on = 0;
    int sph   = 32;
    int hc = 0, sc = 0;
    always @(negedge clk) begin
        if (sl_on) begin
            hc = hc + 1;
            if (hc >= 8) begin
                hc = 0;
                bclk_in = ~bclk_in;
                if (!bclk_in) begin
                    sc = sc + 1;
                    if (sc >= sph) begin
                        sc = 0;
                        ws_in = ~ws_in;
                    end
                end
            end
        end
    end

    // Frame decoder at rising bit-clock edges.
    logic        mon_bclk, mon_ws;
    assign mon_bclk = master_r ? bclk_o : bclk_in;
    assign mon_ws   = master_r ? ws_o   : ws_in;
    logic        prev_ws = 1'b0;
    logic        m_ws, m_sd, m_left;
    int          m_slot = 0, m_off = 0, m_pad = 0;
    logic [17:0] acc_l = '0, acc_r = '0, rx_l = '0, rx_r = '0;
    int          rx_pad = 0, rx_start = 0, rx_done = 0;
    always @(posedge mon_bclk) begin
        m_ws   = mon_ws;
        m_sd   = sdata;
        m_left = (m_ws == ~fmt_r);
        m_off  = fmt_r ? 1 : 0;
        if (m_ws != prev_ws) begin
            m_slot = 0;
            if (m_left) begin
                if (rx_start > 0) begin
                    rx_l   = acc_l;
                    rx_r   = acc_r;
                    rx_pad = m_pad;
                    rx_done = rx_start;
                end
                acc_l = '0; acc_r = '0; m_pad = 0;
                rx_start = rx_start + 1;
            end
        end else begin
            m_slot = m_slot + 1;
        end
        prev_ws = m_ws;
        if (m_slot >= m_off && m_slot < m_off + 18) begin
            if (m_left) acc_l = {acc_l[16:0], m_sd};
            else        acc_r = {acc_r[16:0], m_sd};
        end else if (m_sd) begin
            m_pad = m_pad + 1;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset(input bit m, input bit f);
        rst_n = 1'b0;
        master_r = m;
        fmt_r = f;
        repeat (4) @(negedge clk);
        chk(sdata == 1'b0, "R11 sdata in reset", 64'(sdata), 0);
        chk(in_ready == 1'b1, "R11 in_ready in reset", 64'(in_ready), 1);
        chk(bclk_o == 1'b0, "R11 bclk_o in reset", 64'(bclk_o), 0);
        chk(ws_o == (m & ~f), "R11 ws_o in reset", 64'(ws_o), 64'(m & ~f));
        rst_n = 1'b1;
    endtask

    // Submit a pair right after a left half starts; return the next frame.
    task automatic xfer(input logic [17:0] l, input logic [17:0] r,
                        output logic [17:0] gl, output logic [17:0] gr, output int gp);
        int k;
        k = rx_start;
        wait (rx_start != k);
        k = rx_start;
        @(negedge clk);
        chk(in_ready == 1'b1, "R6 ready before submit", 64'(in_ready), 1);
        in_valid = 1'b1; in_left = l; in_right = r;
        @(negedge clk);
        in_valid = 1'b0;
        chk(in_ready == 1'b0, "R6 ready low after accept", 64'(in_ready), 0);
        wait (rx_done == k + 1);
        gl = rx_l; gr = rx_r; gp = rx_pad;
    endtask

    task automatic check_frame(input string tag, input logic [17:0] gl, input logic [17:0] gr,
                               input int gp, input logic [17:0] el, input logic [17:0] er);
        chk(gl == el, {tag, " left word"}, 64'(gl), 64'(el));
        chk(gr == er, {tag, " right word"}, 64'(gr), 64'(er));
        chk(gp == 0, "R5 pad slots low", 64'(gp), 0);
    endtask

    // fmt, left, right
    localparam logic [36:0] VEC [0:7] = '{
        {1'b0, 18'h1FFFF, 18'h20000},
        {1'b0, 18'h2AAAA, 18'h15555},
        {1'b0, 18'h00001, 18'h3FFFF},
        {1'b0, 18'h20000, 18'h00000},
        {1'b1, 18'h12345, 18'h2BCDE},
        {1'b1, 18'h20001, 18'h1FFFE},
        {1'b1, 18'h3FFFF, 18'h00000},
        {1'b1, 18'h0F0F0, 18'h30303}
    };

    initial begin
        logic [17:0] gl, gr, el, er;
        int gp;
        time t0, t1;

        do_reset(1'b1, 1'b0);

        // R1: master divider periods
        @(posedge bclk_o); t0 = $time;
        @(posedge bclk_o); t1 = $time;
        chk(t1 - t0 == 32, "R1 bclk period", 64'(t1 - t0), 32);
        @(posedge bclk_o); t0 = $time;
        @(negedge bclk_o); t1 = $time;
        chk(t1 - t0 == 16, "R1 bclk high time", 64'(t1 - t0), 16);
        @(ws_o); t0 = $time;
        @(ws_o); t1 = $time;
        chk(t1 - t0 == 1024, "R1 ws half period", 64'(t1 - t0), 1024);

        // Table walk: R3 (fmt 0), R4 (fmt 1), R7 pairing; last entry with
        // external clocks toggling for R10.
        for (int i = 0; i < 8; i++) begin
            if (VEC[i][36] != fmt_r) do_reset(1'b1, VEC[i][36]);
            sl_on = (i == 7);
            el = VEC[i][35:18];
            er = VEC[i][17:0];
            xfer(el, er, gl, gr, gp);
            if (i == 7)
                check_frame("R10 master ignores ext clocks", gl, gr, gp, el, er);
            else if (VEC[i][36])
                check_frame("R4 i2s frame", gl, gr, gp, el, er);
            else
                check_frame("R3 lj frame", gl, gr, gp, el, er);
            if (i == 3) begin
                // R8: no new pair, previous frame repeats; R6 ready back high
                int k;
                k = rx_done;
                wait (rx_done == k + 1);
                chk(rx_l == el && rx_r == er, "R8 repeat pair", {28'd0, rx_l, rx_r}, {28'd0, el, er});
                @(negedge clk);
                chk(in_ready == 1'b1, "R6 ready after latch", 64'(in_ready), 1);
                chk(in_ready && !in_valid, "R7 hold empty after latch", 64'(in_ready), 1);
            end
        end

        // Slave mode, left-justified, 32 slots per half.
        sph = 32; sl_on = 1;
        do_reset(1'b0, 1'b0);
        repeat (20) @(negedge clk);
        chk(bclk_o == 1'b0 && ws_o == 1'b0, "R10 slave outputs low", {62'd0, bclk_o, ws_o}, 0);
        xfer(18'h13579, 18'h2468A, gl, gr, gp);
        check_frame("R9 slave lj", gl, gr, gp, 18'h13579, 18'h2468A);
        xfer(18'h20000, 18'h1FFFF, gl, gr, gp);
        check_frame("R9 slave lj extremes", gl, gr, gp, 18'h20000, 18'h1FFFF);

        // Slave mode, I2S, 20 slots per half.
        sph = 20;
        do_reset(1'b0, 1'b1);
        xfer(18'h3C3C3, 18'h05A5A, gl, gr, gp);
        check_frame("R9 slave i2s", gl, gr, gp, 18'h3C3C3, 18'h05A5A);
        xfer(18'h00001, 18'h20001, gl, gr, gp);
        check_frame("R9 slave i2s short half", gl, gr, gp, 18'h00001, 18'h20001);

        done = 1;
        $display("test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end

    // Watchdog
    always @(posedge clk) begin
        cyc = cyc + 1;
        if (cyc > 150000 && !done) begin
            nchk++;
            nbad++;
            $display("FAIL watchdog act=%0d exp=%0d", cyc, 150000);
            $display("test done: total=%0d bad=%0d", nchk, nbad);
            $finish;
        end
    end
endmodule